// File: doc/BRIEF.md
# EEPROM Page-Write Sequencer

This block sits above a byte-level serial-bus master engine. It turns one block-write request into a series of bus transactions that never run past a page edge in the target memory. A request carries a slave address byte, a start offset, a byte count and a stream of data bytes. The sequencer splits the request into transactions of up to `PAGE_BYTES` bytes. Each transaction opens with START, sends the slave address byte and the running offset, and then moves data bytes from the stream until it reaches a page edge or the end of the request. It closes with STOP and then waits out the memory's internal write cycle.

The first transaction of a request whose offset is not page-aligned is treated in one of two ways. If the request is longer than one page, that transaction is cut at the next page edge and followed by a shorter, separately programmed wait. Otherwise the whole request goes out as one transaction. When the sequencer finishes it gives a one-cycle done pulse, an error flag and the count of data bytes the memory acknowledged. Before it starts, it checks a lost-arbitration flag, and it gives up as soon as any byte is not acknowledged.

Top module: `eeprom_page_writer`

## Requirements
- R1: Command codes on `cmd_code` are START=0, WRITE=1 and STOP=2. An aligned request is sent as transactions of `PAGE_BYTES` data bytes, with a shorter last one if needed. Each transaction is START, WRITE slave byte, offset bytes, WRITE data bytes, STOP.
- R2: The offset sent in each transaction is the running offset of that transaction's first data byte. With `OFS_BYTES`=2 it is sent as two WRITE commands, bits 15:8 first and bits 7:0 second.
- R3: If the start offset is not a multiple of `PAGE_BYTES` and the count exceeds `PAGE_BYTES`, the first transaction carries only the bytes up to the next page edge. All later transactions begin page-aligned.
- R4: If the start offset is not a multiple of `PAGE_BYTES` and the count is at most `PAGE_BYTES`, the whole request is one transaction, even when it crosses a page edge.
- R5: Take the clock edge that samples the STOP completion. After the unaligned head transaction, the next START (or done) is presented `HEAD_WAIT`+1 edges after that edge. After any other transaction the gap is `PAGE_WAIT`+1 edges.
- R6: If `arb_lost` is high when a request is accepted, the block pulses `arb_clr` together with `done` and `err` and issues no command.
- R7: A request with count 0 completes with `done` one edge after it is accepted, without `err`, and issues no command.
- R8: If any WRITE completes with `eng_ack_ok`=0, no further command is issued. `done` and `err` pulse, and `bytes_written` holds the number of data bytes acknowledged before it.
- R9: A request that succeeds ends with a single one-cycle `done` pulse, `err` low and `bytes_written` equal to the count.
- R10: One data byte is taken from the stream (`wr_ready`) exactly when a data WRITE command is accepted. The bytes go out in stream order.
- R11: After reset, `req_ready` is 1 and `cmd_valid`, `done`, `err` and `bytes_written` are 0.
- R12: A START or STOP command presented without `cmd_ready` stays presented, with the same code and byte, until it is accepted. No command is presented while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and can take a request |
| req_slave | input | 8 | Slave address byte (write direction) |
| req_offset | input | 8*OFS_BYTES | Start offset in the memory |
| req_count | input | CNT_W | Number of data bytes |
| arb_lost | input | 1 | Lost-arbitration flag from the bus engine |
| arb_clr | output | 1 | One-cycle clear for the lost-arbitration flag |
| wr_data | input | 8 | Data stream byte |
| wr_valid | input | 1 | Data stream valid |
| wr_ready | output | 1 | Data byte consumed |
| cmd_valid | output | 1 | Command presented to the byte engine |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_code | output | 2 | START=0, WRITE=1, STOP=2 |
| cmd_byte | output | 8 | Byte for a WRITE command |
| eng_done | input | 1 | Byte engine finished the accepted command |
| eng_ack_ok | input | 1 | Byte was acknowledged (valid with `eng_done`) |
| done | output | 1 | Request finished (pulse) |
| err | output | 1 | Request failed (valid with `done`) |
| bytes_written | output | CNT_W | Data bytes acknowledged in the last request |

## Verification
The bench builds the block with 8-byte pages, two offset bytes, a head wait of 3 and a page wait of 6. Those short waits keep each gap cheap to measure and leave the two wait lengths distinct, so a gap of the wrong kind shows up at once. The two-byte offset brings the high-byte ordering and offsets above 255 into reach. Because `cmd_ready` stalls on a fixed pattern, some START, STOP and data commands are held across cycles.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_STOP  = 2'd2
  } pw_cmd_e;

  // True when the first segment must be cut at the next page edge.
  function automatic logic head_split(input int unsigned ofs, input int unsigned rem,
                                      input int unsigned page, input logic first);
    return first && ((ofs % page) != 0) && (rem > page);
  endfunction

  // Number of data bytes in the segment that starts at ofs with rem bytes left.
  function automatic int unsigned seg_len(input int unsigned ofs, input int unsigned rem,
                                          input int unsigned page, input logic first);
    int unsigned in_page;
    in_page = ofs % page;
    if (head_split(ofs, rem, page, first)) return page - in_page;
    if (in_page != 0)                      return rem;
    return (rem < page) ? rem : page;
  endfunction

endpackage

// File: rtl/pw_wait_timer.sv
module pw_wait_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pw_cmd_issue.sv
module pw_cmd_issue (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic cmd_ready,
  input  logic eng_done,
  output logic cmd_valid,
  output logic fire,
  output logic complete
);
  logic pending_q;

  assign cmd_valid = want && !pending_q;
  assign fire      = cmd_valid && cmd_ready;
  assign complete  = pending_q && eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending_q <= 1'b0;
    else if (fire)     pending_q <= 1'b1;
    else if (complete) pending_q <= 1'b0;
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int PAGE_BYTES = 8,
  parameter int CNT_W      = 8,
  parameter int OFS_BYTES  = 2,
  parameter int HEAD_WAIT  = 32,
  parameter int PAGE_WAIT  = 50
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [7:0]             req_slave,
  input  logic [8*OFS_BYTES-1:0] req_offset,
  input  logic [CNT_W-1:0]       req_count,
  input  logic                   arb_lost,
  output logic                   arb_clr,
  input  logic [7:0]             wr_data,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [1:0]             cmd_code,
  output logic [7:0]             cmd_byte,
  input  logic                   eng_done,
  input  logic                   eng_ack_ok,
  output logic                   done,
  output logic                   err,
  output logic [CNT_W-1:0]       bytes_written
);
  import pw_pkg::*;

  localparam int OFS_W    = 8 * OFS_BYTES;
  localparam int WAIT_MAX = (HEAD_WAIT > PAGE_WAIT) ? HEAD_WAIT : PAGE_WAIT;
  localparam int WAIT_W   = (WAIT_MAX < 1) ? 1 : $clog2(WAIT_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_OFSH, ST_OFSL, ST_DATA, ST_STOP, ST_WAIT
  } pw_state_e;

  pw_state_e        state_q;
  logic [7:0]       slave_q;
  logic [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] remain_q, seg_q, written_q;
  logic             head_q, done_q, err_q, arb_clr_q;

  // named internal events
  logic        want, fire, complete, byte_ack, byte_nack, data_ack, timer_load, timer_zero;
  pw_cmd_e     code_e;
  logic [7:0]  ofs_hi;
  logic [31:0] plan_ofs, plan_rem;
  logic        plan_first, plan_split;
  int unsigned plan_len;

  generate
    if (OFS_BYTES > 1) begin : g_ofs_two
      assign ofs_hi = ofs_q[OFS_W-1 -: 8];
    end else begin : g_ofs_one
      assign ofs_hi = 8'h00;
    end
  endgenerate

  // segment planning, shared by request accept and the post-wait restart
  assign plan_first = (state_q == ST_IDLE);
  assign plan_ofs   = plan_first ? 32'(req_offset) : 32'(ofs_q);
  assign plan_rem   = plan_first ? 32'(req_count)  : 32'(remain_q);
  assign plan_len   = seg_len(plan_ofs, plan_rem, PAGE_BYTES, plan_first);
  assign plan_split = head_split(plan_ofs, plan_rem, PAGE_BYTES, plan_first);

  always_comb begin
    want   = 1'b0;
    code_e = CMD_WRITE;
    unique case (state_q)
      ST_START: begin want = 1'b1; code_e = CMD_START; end
      ST_STOP:  begin want = 1'b1; code_e = CMD_STOP;  end
      ST_ADDR, ST_OFSH, ST_OFSL: want = 1'b1;
      ST_DATA:  want = wr_valid;
      default:  want = 1'b0;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_ADDR: cmd_byte = slave_q;
      ST_OFSH: cmd_byte = ofs_hi;
      ST_OFSL: cmd_byte = ofs_q[7:0];
      ST_DATA: cmd_byte = wr_data;
      default: cmd_byte = 8'h00;
    endcase
  end

  pw_cmd_issue u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .cmd_ready (cmd_ready),
    .eng_done  (eng_done),
    .cmd_valid (cmd_valid),
    .fire      (fire),
    .complete  (complete)
  );

  assign byte_ack   = complete && eng_ack_ok && (code_e == CMD_WRITE);
  assign byte_nack  = complete && !eng_ack_ok && (code_e == CMD_WRITE);
  assign data_ack   = byte_ack && (state_q == ST_DATA);
  assign timer_load = complete && (state_q == ST_STOP);

  pw_wait_timer #(.W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (head_q ? WAIT_W'(HEAD_WAIT) : WAIT_W'(PAGE_WAIT)),
    .zero     (timer_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      slave_q   <= '0;
      ofs_q     <= '0;
      remain_q  <= '0;
      seg_q     <= '0;
      written_q <= '0;
      head_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      arb_clr_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      arb_clr_q <= 1'b0;
      if (byte_nack) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        err_q   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (req_valid) begin
            slave_q   <= req_slave;
            ofs_q     <= req_offset;
            remain_q  <= req_count;
            written_q <= '0;
            if (arb_lost) begin
              done_q    <= 1'b1;
              err_q     <= 1'b1;
              arb_clr_q <= 1'b1;
            end else if (req_count == '0) begin
              done_q <= 1'b1;
            end else begin
              seg_q   <= CNT_W'(plan_len);
              head_q  <= plan_split;
              state_q <= ST_START;
            end
          end
          ST_START: if (complete) state_q <= ST_ADDR;
          ST_ADDR:  if (complete) state_q <= (OFS_BYTES > 1) ? ST_OFSH : ST_OFSL;
          ST_OFSH:  if (complete) state_q <= ST_OFSL;
          ST_OFSL:  if (complete) state_q <= ST_DATA;
          ST_DATA:  if (data_ack) begin
            written_q <= written_q + CNT_W'(1);
            ofs_q     <= ofs_q + OFS_W'(1);
            remain_q  <= remain_q - CNT_W'(1);
            seg_q     <= seg_q - CNT_W'(1);
            if (seg_q == CNT_W'(1)) state_q <= ST_STOP;
          end
          ST_STOP:  if (complete) state_q <= ST_WAIT;
          ST_WAIT:  if (timer_zero) begin
            if (remain_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              seg_q   <= CNT_W'(plan_len);
              head_q  <= plan_split;
              state_q <= ST_START;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign wr_ready      = fire && (state_q == ST_DATA);
  assign cmd_code      = code_e;
  assign done          = done_q;
  assign err           = err_q;
  assign arb_clr       = arb_clr_q;
  assign bytes_written = written_q;
endmodule

// File: rtl/pw_checks.sv
module pw_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_code,
  input logic [7:0] cmd_byte,
  input logic       wr_ready,
  input logic       done,
  input logic       err,
  input logic       arb_clr
);
  // R12
  bus_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && cmd_code != 2'd1) |=>
      (cmd_valid && $stable(cmd_code) && $stable(cmd_byte)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  // R10
  data_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (cmd_valid && cmd_ready && cmd_code == 2'd1));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R6
  arb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_clr |-> (done && err));
endmodule

bind eeprom_page_writer pw_checks u_pw_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .cmd_byte  (cmd_byte),
  .wr_ready  (wr_ready),
  .done      (done),
  .err       (err),
  .arb_clr   (arb_clr)
);

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  localparam int HW = 3;
  localparam int PW = 6;
  localparam int PG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_slave = 8'h00;
  logic [15:0] req_offset = 16'h0;
  logic [7:0]  req_count = 8'h0;
  logic        arb_lost = 1'b0;
  logic        arb_clr;
  logic [7:0]  wr_data = 8'h00;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_code;
  logic [7:0]  cmd_byte;
  logic        eng_done = 1'b0;
  logic        eng_ack_ok = 1'b0;
  logic        done;
  logic        err;
  logic [7:0]  bytes_written;

  eeprom_page_writer #(
    .PAGE_BYTES(PG), .CNT_W(8), .OFS_BYTES(2), .HEAD_WAIT(HW), .PAGE_WAIT(PW)
  ) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_slave(req_slave), .req_offset(req_offset), .req_count(req_count),
    .arb_lost(arb_lost), .arb_clr(arb_clr), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_byte(cmd_byte), .eng_done(eng_done),
    .eng_ack_ok(eng_ack_ok), .done(done), .err(err), .bytes_written(bytes_written)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [1:0] code;
    logic [7:0] b;
    int         w;
  } item_t;

  item_t      exp_q[$];
  logic [7:0] data_q[$];
  int checks = 0, failures = 0;
  int cyc = 0, cmd_seen = 0, wr_cnt = 0, nack_k = -1;
  int stop_cyc = 0, gap_exp = 0;
  bit gap_arm = 0, pend_done = 0, pend_ack = 0, pend_stop = 0, pop_pending = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // byte engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (pop_pending) begin
        if (data_q.size() > 0) void'(data_q.pop_front());
        pop_pending = 0;
      end
      eng_done   = pend_done;
      eng_ack_ok = pend_ack;
      if (pend_done && pend_stop) begin
        gap_arm  = 1;
        stop_cyc = cyc;
      end
      pend_done = 0;
      pend_stop = 0;
      cmd_ready = (cyc % 4) != 0;
      wr_valid  = data_q.size() > 0;
      wr_data   = (data_q.size() > 0) ? data_q[0] : 8'h00;
      #1;
      if (gap_arm && ((cmd_valid && cmd_code == 2'd0) || done)) begin
        chk(cyc - stop_cyc == gap_exp + 2, "R5 wait gap", cyc - stop_cyc, gap_exp + 2);
        gap_arm = 0;
      end
      if (wr_ready) begin
        chk(cmd_valid && cmd_ready && cmd_code == 2'd1, "R10 stream take", 0, 1);
        pop_pending = 1;
      end
      if (cmd_valid && cmd_ready) begin
        item_t it;
        cmd_seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected command", int'(cmd_code), -1);
          it.code = cmd_code; it.b = cmd_byte; it.w = 0;
        end else begin
          it = exp_q.pop_front();
          chk(cmd_code == it.code, "R1 command code", int'(cmd_code), int'(it.code));
          if (it.code == 2'd1)
            chk(cmd_byte == it.b, "R2 command byte", int'(cmd_byte), int'(it.b));
        end
        pend_done = 1;
        if (cmd_code == 2'd1) begin
          wr_cnt++;
          pend_ack = (wr_cnt != nack_k);
        end else begin
          pend_ack = 1;
        end
        pend_stop = (cmd_code == 2'd2);
        if (cmd_code == 2'd2) gap_exp = it.w;
      end
    end
  end

  // driver: builds the expected command list per byte, then fires one request
  task automatic run_req(input int off, input int cnt, input bit arb, input int nk,
                         input string tag);
    bit   unal, split, head_tx, cut;
    int   wc, exp_wr, seen0, t;
    logic [7:0] slave;
    slave = 8'hA0 + 8'(off % 7) * 8'h2;
    unal = (off % PG) != 0;
    split = unal && cnt > PG;
    head_tx = 0; cut = 0; wc = 0; exp_wr = 0;
    exp_q.delete();
    if (!arb) begin
      for (int i = 0; i < cnt && !cut; i++) begin
        int  j;
        bit  newtx;
        j = off + i;
        newtx = (i == 0) || (((j % PG) == 0) && !(unal && !split));
        if (newtx) begin
          if (i > 0) exp_q.push_back('{2'd2, 8'h00, head_tx ? HW : PW});
          head_tx = (i == 0) && split;
          exp_q.push_back('{2'd0, 8'h00, 0});
          for (int k = 0; k < 3 && !cut; k++) begin
            logic [7:0] bv;
            bv = (k == 0) ? slave : (k == 1) ? 8'(j >> 8) : 8'(j);
            exp_q.push_back('{2'd1, bv, 0});
            wc++;
            if (wc == nk) cut = 1;
          end
        end
        if (!cut) begin
          exp_q.push_back('{2'd1, 8'(8'h30 + i), 0});
          wc++;
          if (wc == nk) cut = 1;
          else exp_wr++;
        end
      end
      if (!cut && cnt > 0) exp_q.push_back('{2'd2, 8'h00, head_tx ? HW : PW});
    end
    data_q.delete();
    for (int i = 0; i < cnt; i++) data_q.push_back(8'(8'h30 + i));
    wr_cnt = 0;
    nack_k = nk;
    seen0 = cmd_seen;
    @(negedge clk);
    req_valid  = 1;
    req_slave  = slave;
    req_offset = 16'(off);
    req_count  = 8'(cnt);
    arb_lost   = arb;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    forever begin
      #2;
      if (done || t > 3000) break;
      t++;
      @(negedge clk);
    end
    chk(done, {tag, " done seen"}, int'(done), 1);
    chk(err == (arb || cut), {tag, " err"}, int'(err), int'(arb || cut));
    chk(bytes_written == 8'(exp_wr), {tag, " bytes_written"}, int'(bytes_written), exp_wr);
    if (arb) begin
      chk(arb_clr, "R6 arb_clr pulse", int'(arb_clr), 1);
      chk(cmd_seen == seen0, "R6 no commands", cmd_seen - seen0, 0);
    end
    if (cnt == 0 && !arb)
      chk(cmd_seen == seen0 && t == 0, "R7 zero count", cmd_seen - seen0 + t, 0);
    arb_lost = 0;
    seen0 = cmd_seen;
    repeat (8) @(negedge clk);
    #2;
    chk(cmd_seen == seen0, {tag, " quiet after done"}, cmd_seen - seen0, 0);
    chk(exp_q.size() == 0, {tag, " all commands issued"}, exp_q.size(), 0);
    gap_arm = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R11 reset state
    chk(req_ready == 1'b1, "R11 req_ready", int'(req_ready), 1);
    chk(!cmd_valid && !done && !err, "R11 outputs idle", int'(cmd_valid || done || err), 0);
    chk(bytes_written == 8'h0, "R11 bytes_written", int'(bytes_written), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_req(16'h0010, 16, 0, -1, "R1 R9 aligned two pages");
    run_req(16'h0140, 8, 0, -1, "R1 exact page");
    run_req(16'h0105, 12, 0, -1, "R3 unaligned head split");
    run_req(16'h0023, 4, 0, -1, "R4 unaligned short");
    run_req(16'h0026, 5, 0, -1, "R4 crossing single transaction");
    run_req(16'h0200, 0, 0, -1, "R7 zero count");
    run_req(16'h0000, 5, 1, -1, "R6 arbitration lost");
    run_req(16'h0000, 10, 0, 6, "R8 nack on data");
    run_req(16'h0008, 10, 0, 1, "R8 nack on address");
    run_req(16'h0000, 12, 0, 15, "R8 nack in second page");
    run_req(16'h0003, 20, 0, -1, "R10 R5 long unaligned");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule